// File: doc/BRIEF.md
# ADC Host Register Interface

This block sits between an 8-bit host register port and an analog-to-digital converter whose result is wider than one byte (10 bits by default, up to 16). The host programs a small control register that chooses how conversions are started and whether an end of conversion raises an interrupt. It then collects each result as two separate byte reads. Conversions start in one of two ways. The host can write to a dedicated start address. Otherwise each rising edge of a slow periodic timer clock starts one. A free-running mode restarts the converter by itself after every completed result.

Each start request becomes a start pulse of a fixed number of bus-clock cycles. A rising edge on the converter's end-of-conversion line latches the result into a holding buffer, which always keeps the newest value. The same edge sets a completion flag. The host can poll that flag through the status register, and the flag can also drive a level interrupt request. Reading the low data byte acknowledges the result.

Register map (3-bit address): 0 control, 1 status, 2 result low byte, 3 result high byte, 4 start strobe (write only). Control bits: bit 0 `host_sel` (1 = host-started, 0 = timer-started), bit 1 `irq_en`, bit 2 `free_run`. Status bits: bit 0 completion flag, bit 1 synchronized timer level.

Top module: `adc_host_if`

## Requirements
- R1: A write to address 0 stores bits 2:0 of the write data. A read of address 0 returns those three bits, with bits 7:3 reading 0.
- R2: A write to address 4 starts a conversion only while control bit 0 is 1. While control bit 0 is 0, such a write produces no start pulse.
- R3: While control bit 0 is 0, each rising edge of `timer_clk` (after a two-flop synchronizer) produces exactly one start pulse. While control bit 0 is 1, timer edges produce none.
- R4: `adc_start` stays high for exactly PULSE_W clock cycles per accepted trigger. A trigger that arrives while the pulse is high is ignored.
- R5: A rising edge on `adc_eoc` captures `adc_data` into the result buffer and sets status bit 0 on the following clock edge.
- R6: A read of address 2 (low byte) clears status bit 0. A read of address 3 (high byte) leaves it set. If a new end-of-conversion edge arrives in the same cycle as the clear, the flag is set.
- R7: `irq` is high one cycle after status bit 0 is set while control bit 1 is 1. `irq` stays low whenever control bit 1 is 0. `irq` falls after the low byte is read.
- R8: Address 2 returns result bits 7:0. Address 3 returns the remaining upper result bits right-aligned in bit 0 upward, with the unused upper bits as 0.
- R9: While control bit 2 is 1, every end-of-conversion edge triggers a new start pulse without host action. The buffer then holds the most recent result.
- R10: Status bit 1 follows the level of `timer_clk` after the two-flop synchronizer.
- R11: After reset, all registers, `irq`, `adc_start` and `host_rdata` are 0. Reads of address 4 and of addresses 5 to 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Register address |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data, valid the cycle after `host_rd` |
| irq | output | 1 | Level interrupt request |
| timer_clk | input | 1 | Slow periodic trigger clock, asynchronous |
| adc_start | output | 1 | Start-of-conversion pulse to the converter |
| adc_eoc | input | 1 | End-of-conversion level from the converter |
| adc_data | input | RES_W | Conversion result |

## Verification
The properties assume that `adc_eoc` and `adc_data` are synchronous to `clk`, and that `adc_data` is stable whenever `adc_eoc` rises. They also assume the converter drops `adc_eoc` once it sees a start pulse, so that each completed conversion gives exactly one rising edge. The bench's converter model meets these conditions. It changes its outputs only on the falling clock edge, drops completion on seeing a start, and raises it a fixed number of cycles later together with the new data. The timer clock is held in each phase far longer than a start pulse plus a conversion, so timer edges never land inside an active pulse except where the retrigger case is tested on purpose.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_STAT = 3'd1;
  localparam logic [REG_AW-1:0] A_RLO  = 3'd2;
  localparam logic [REG_AW-1:0] A_RHI  = 3'd3;
  localparam logic [REG_AW-1:0] A_GO   = 3'd4;

  typedef struct packed {
    logic free_run;
    logic irq_en;
    logic host_sel;
  } ctrl_t;
endpackage

// File: rtl/adc_host_regs.sv
module adc_host_regs
  import adc_host_pkg::*;
#(
  parameter int ADDR_W = REG_AW,
  parameter int RES_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  input  logic [RES_W-1:0]  result,
  input  logic              done_flag,
  input  logic              timer_lvl,
  output logic [7:0]        host_rdata,
  output ctrl_t             ctrl,
  output logic              go_wr,
  output logic              rd_lo
);
  localparam int EXT_W = 16;

  logic [EXT_W-1:0] res_ext;
  logic [7:0]       rd_mux;

  assign res_ext = EXT_W'(result);
  assign go_wr   = host_wr && (host_addr == ADDR_W'(A_GO));
  assign rd_lo   = host_rd && (host_addr == ADDR_W'(A_RLO));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (host_wr && host_addr == ADDR_W'(A_CTRL)) begin
      ctrl <= ctrl_t'(host_wdata[2:0]);
    end
  end

  always_comb begin
    rd_mux = 8'h00;
    case (host_addr)
      ADDR_W'(A_CTRL): rd_mux = {5'b0, ctrl};
      ADDR_W'(A_STAT): rd_mux = {6'b0, timer_lvl, done_flag};
      ADDR_W'(A_RLO):  rd_mux = res_ext[7:0];
      ADDR_W'(A_RHI):  rd_mux = res_ext[15:8];
      default:         rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= 8'h00;
    end else if (host_rd) begin
      host_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/adc_host_trig.sv
module adc_host_trig #(
  parameter int PULSE_W = 4,
  parameter int SYNC_N  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic timer_clk,
  input  logic host_sel,
  input  logic free_run,
  input  logic go_wr,
  input  logic eoc_rise,
  output logic timer_lvl,
  output logic trig,
  output logic adc_start
);
  localparam int CW = (PULSE_W > 1) ? $clog2(PULSE_W) : 1;

  logic [SYNC_N-1:0] sync_q;
  logic              lvl_q;
  logic [CW-1:0]     cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_N-2:0], timer_clk};
      lvl_q  <= sync_q[SYNC_N-1];
    end
  end

  assign timer_lvl = sync_q[SYNC_N-1];
  assign trig = (host_sel ? go_wr : (timer_lvl && !lvl_q))
              || (free_run && eoc_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      adc_start <= 1'b0;
      cnt_q     <= '0;
    end else if (!adc_start) begin
      if (trig) begin
        adc_start <= 1'b1;
        cnt_q     <= CW'(PULSE_W - 1);
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else begin
      adc_start <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_host_buf.sv
module adc_host_buf #(
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adc_eoc,
  input  logic [RES_W-1:0] adc_data,
  input  logic             rd_lo,
  input  logic             irq_en,
  output logic [RES_W-1:0] result,
  output logic             done_flag,
  output logic             eoc_rise,
  output logic             irq
);
  logic eoc_q;

  assign eoc_rise = adc_eoc && !eoc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      eoc_q     <= 1'b0;
      result    <= '0;
      done_flag <= 1'b0;
      irq       <= 1'b0;
    end else begin
      eoc_q <= adc_eoc;
      if (eoc_rise) begin
        result    <= adc_data;
        done_flag <= 1'b1;
      end else if (rd_lo) begin
        done_flag <= 1'b0;
      end
      irq <= irq_en && done_flag;
    end
  end
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if
  import adc_host_pkg::*;
#(
  parameter int ADDR_W  = REG_AW,
  parameter int RES_W   = 10,
  parameter int PULSE_W = 4,
  parameter int SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  output logic              irq,
  input  logic              timer_clk,
  output logic              adc_start,
  input  logic              adc_eoc,
  input  logic [RES_W-1:0]  adc_data
);
  ctrl_t            ctrl;
  logic             go_wr;
  logic             rd_lo;
  logic             trig;
  logic             timer_lvl;
  logic             eoc_rise;
  logic             done_flag;
  logic [RES_W-1:0] result;

  adc_host_regs #(.ADDR_W(ADDR_W), .RES_W(RES_W)) u_regs (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .result(result),
    .done_flag(done_flag), .timer_lvl(timer_lvl), .host_rdata(host_rdata),
    .ctrl(ctrl), .go_wr(go_wr), .rd_lo(rd_lo)
  );

  adc_host_trig #(.PULSE_W(PULSE_W), .SYNC_N(SYNC_N)) u_trig (
    .clk(clk), .rst(rst), .timer_clk(timer_clk), .host_sel(ctrl.host_sel),
    .free_run(ctrl.free_run), .go_wr(go_wr), .eoc_rise(eoc_rise),
    .timer_lvl(timer_lvl), .trig(trig), .adc_start(adc_start)
  );

  adc_host_buf #(.RES_W(RES_W)) u_buf (
    .clk(clk), .rst(rst), .adc_eoc(adc_eoc), .adc_data(adc_data),
    .rd_lo(rd_lo), .irq_en(ctrl.irq_en), .result(result),
    .done_flag(done_flag), .eoc_rise(eoc_rise), .irq(irq)
  );
endmodule

// File: rtl/adc_host_chk.sv
module adc_host_chk #(
  parameter int PULSE_W = 4
) (
  input logic clk,
  input logic rst,
  input logic adc_start,
  input logic trig,
  input logic eoc_rise,
  input logic rd_lo,
  input logic done_flag,
  input logic irq
);
  logic [15:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst) hi_cnt <= '0;
    else if (adc_start) hi_cnt <= hi_cnt + 1'b1;
    else hi_cnt <= '0;
  end

  // R4
  pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(adc_start) |-> hi_cnt == 16'(PULSE_W));

  // R4
  pulse_max_chk: assert property (@(posedge clk) disable iff (rst)
    adc_start |-> hi_cnt < 16'(PULSE_W));

  // R2 R3 R9
  start_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(adc_start) |-> $past(trig));

  // R5
  eoc_set_chk: assert property (@(posedge clk) disable iff (rst)
    eoc_rise |=> done_flag);

  // R6
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !eoc_rise) |=> !done_flag);

  // R7
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(done_flag));
endmodule

bind adc_host_if adc_host_chk #(.PULSE_W(PULSE_W)) u_chk (
  .clk(clk), .rst(rst), .adc_start(adc_start), .trig(trig),
  .eoc_rise(eoc_rise), .rd_lo(rd_lo), .done_flag(done_flag), .irq(irq)
);

// File: tb/adc_host_if_bench.sv
module adc_host_if_bench;
  localparam int CLK_P   = 10;
  localparam int RES_W   = 10;
  localparam int PULSE_W = 4;
  localparam int CONV    = 6;
  localparam int ADDR_W  = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] host_addr = '0;
  logic              host_wr = 1'b0;
  logic              host_rd = 1'b0;
  logic [7:0]        host_wdata = '0;
  logic [7:0]        host_rdata;
  logic              irq;
  logic              timer_clk = 1'b0;
  logic              adc_start;
  logic              adc_eoc = 1'b0;
  logic [RES_W-1:0]  adc_data = '0;

  int n_chk = 0;
  int n_bad = 0;

  // converter model state
  int starts = 0, dones = 0, last_w = 0, hcnt = 0, busy_cnt = 0, last_val = 0;
  bit prev_s = 0, busy = 0;
  int seed = 0;
  bit auto_inc = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_host_if #(.RES_W(RES_W), .PULSE_W(PULSE_W)) u_adc_host_if (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .irq(irq), .timer_clk(timer_clk), .adc_start(adc_start),
    .adc_eoc(adc_eoc), .adc_data(adc_data)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (adc_start) hcnt = hcnt + 1;
      else if (prev_s) begin last_w = hcnt; hcnt = 0; end
      if (adc_start && !prev_s) begin
        starts = starts + 1; busy = 1; busy_cnt = CONV; adc_eoc = 1'b0;
      end else if (busy) begin
        busy_cnt = busy_cnt - 1;
        if (busy_cnt == 0) begin
          busy = 0;
          last_val = (auto_inc ? seed + dones : seed) % (1 << RES_W);
          adc_data = RES_W'(last_val);
          adc_eoc = 1'b1;
          dones = dones + 1;
        end
      end
      prev_s = adc_start;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    host_addr = ADDR_W'(a); host_wdata = 8'(d); host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    host_addr = ADDR_W'(a); host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    d = int'(host_rdata);
  endtask

  task automatic wait_done();
    int d0 = dones;
    while (dones == d0) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int v, s0, d0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check("R11 adc_start", int'(adc_start), 0);
    check("R11 irq", int'(irq), 0);
    check("R11 rdata", int'(host_rdata), 0);
    rd(0, v); check("R11 ctrl", v, 0);
    rd(1, v); check("R11 stat", v, 0);
    rd(2, v); check("R11 lo", v, 0);

    // R1 control readback
    wr(0, 8'hFF); rd(0, v); check("R1 ctrl all", v, 7);
    wr(0, 8'h05); rd(0, v); check("R1 ctrl 5", v, 5);
    wr(0, 0);

    // R2 host start gated
    s0 = starts;
    wr(4, 0); idle(15);
    check("R2 no start in timer mode", starts, s0);
    wr(0, 1); wr(4, 0); wait_done();
    check("R2 start in host mode", starts, s0 + 1);
    check("R4 pulse width", last_w, PULSE_W);
    rd(2, v);

    // R4 retrigger ignored
    s0 = starts;
    wr(4, 0); wr(4, 0); wait_done(); idle(4);
    check("R4 retrigger ignored", starts, s0 + 1);
    check("R4 pulse width again", last_w, PULSE_W);
    rd(2, v);

    // R3 timer ignored in host mode
    s0 = starts;
    for (int k = 0; k < 3; k++) begin
      timer_clk = 1'b1; idle(12); timer_clk = 1'b0; idle(12);
    end
    check("R3 timer ignored in host mode", starts, s0);
    wr(0, 0);
    for (int k = 0; k < 4; k++) begin
      timer_clk = 1'b1; idle(12); timer_clk = 1'b0; idle(12);
    end
    check("R3 one start per timer edge", starts, s0 + 4);
    check("R4 timer pulse width", last_w, PULSE_W);
    rd(2, v);

    // R10 timer level in status
    timer_clk = 1'b1; idle(4);
    rd(1, v); check("R10 timer level high", (v >> 1) & 1, 1);
    wr(0, 1);
    timer_clk = 1'b0; idle(4);
    rd(1, v); check("R10 timer level low", (v >> 1) & 1, 0);

    // R5 R6 R7 R8 exhaustive code sweep
    for (int c = 0; c < (1 << RES_W); c++) begin
      seed = c;
      wr(0, 1 | ((c & 1) << 1));
      wr(4, 0);
      wait_done();
      rd(1, v); check("R5 flag set", v, 1);
      check("R7 irq follows enable", int'(irq), c & 1);
      rd(3, v); check("R8 high byte", v, c >> 8);
      if ((c % 64) == 0) begin
        rd(1, v); check("R6 high read keeps flag", v & 1, 1);
      end
      rd(2, v); check("R8 low byte", v, c & 255);
      @(negedge clk);
      check("R7 irq cleared", int'(irq), 0);
      rd(1, v); check("R6 low read clears flag", v & 1, 0);
    end

    // R9 free-running most-recent data
    seed = 100; auto_inc = 1'b1;
    s0 = starts; d0 = dones;
    wr(0, 5); wr(4, 0);
    while (dones < d0 + 5) @(negedge clk);
    wr(0, 1); idle(25);
    check("R9 restarts without host", (dones - d0) >= 5 ? 1 : 0, 1);
    check("R9 starts match completions", starts - s0, dones - d0);
    rd(3, v); check("R9 newest high", v, last_val >> 8);
    rd(2, v); check("R9 newest low", v, last_val & 255);
    auto_inc = 1'b0;

    // R11 unmapped reads
    rd(4, v); check("R11 go read", v, 0);
    for (int a = 5; a < 8; a++) begin
      rd(a, v); check("R11 unmapped", v, 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule